// File: doc/BRIEF.md
# Nibble Time-Slot Switch

This block exchanges 4-bit sub-channels between serial time-division streams. Every stream carries 2.048 Mb/s, and each frame splits into 64 nibble slots of four bits. A nibble slot is therefore a 32 kb/s channel. The block runs from a clock at twice the bit rate. Each input bit lasts two clocks and is sampled on the second of them.

Eight input streams are captured nibble by nibble into a data memory that holds two frames. While one frame is being written, the previous one is read. A connection memory holds one entry per output stream and output nibble slot. Each entry names a source stream and a source nibble, and carries an enable. The four serial outputs are rebuilt from these entries one bit at a time.

In the default blocking mode, any of the eight inputs can feed any output slot, which gives a 512 x 256 nibble matrix. In non-blocking mode, a table of four stream picks narrows the source choice to four chosen inputs, which gives a 256 x 256 matrix. A frame pulse realigns the internal frame count.

Top module: `nibble_tdm_switch`

## Requirements
- R1: A frame lasts 512 clocks. Frame bit k occupies clocks 2k and 2k+1. Each input is sampled on clock 2k+1. When `fpIn` is high in a clock, the next clock is clock 0 of a frame.
- R2: Nibble slot n occupies frame bits 4n to 4n+3, most significant bit first, on every input and every output.
- R3: A connection-memory entry is written in a clock with `cmWe` high, and is in use from the next clock. `cmAddr[7:6]` selects the output stream and `cmAddr[5:0]` the output slot. `cmData[9]` is the enable, `cmData[8:6]` the source stream and `cmData[5:0]` the source nibble.
- R4: An enabled output slot in frame F+1 carries the source nibble that was captured in frame F.
- R5: In blocking mode (`nbMode` = 0), the source stream field selects any of the eight inputs directly. One source may feed several outputs and slots in the same frame.
- R6: In non-blocking mode (`nbMode` = 1), the source stream is pick entry i, where i is `cmData[7:6]` of the entry. Pick entry i is `streamPick[3i+2:3i]`. Bit 8 of the entry has no effect.
- R7: An output slot whose entry is disabled drives 0 for all four of its bits, whatever the input data.
- R8: After reset, every connection entry is disabled, the frame count is at clock 0 and all outputs are 0.
- R9: Output slot 0 of a frame can take nibble 63 of the previous frame, which completes in that frame's last clock, and delivers it correctly.
- R10: An output changes only at the start of a bit period, so both clocks of a bit carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, twice the stream bit rate |
| rstN | input | 1 | Asynchronous reset, active low |
| fpIn | input | 1 | Frame pulse; the following clock starts a frame |
| serIn | input | 8 | Serial input streams |
| nbMode | input | 1 | 0 = blocking 8-to-4, 1 = non-blocking through the pick table |
| streamPick | input | 12 | Four 3-bit input-stream picks for non-blocking mode |
| cmWe | input | 1 | Connection-memory write strobe |
| cmAddr | input | 8 | Output stream (bits 7:6) and output slot (bits 5:0) |
| cmData | input | 10 | Enable (bit 9), source stream (8:6), source nibble (5:0) |
| serOut | output | 4 | Serial output streams |

## Verification
The hardest case to reach is the frame seam. The last input nibble completes on the same clock that launches bit 0 of the next frame, so a route from nibble 63 into output slot 0 needs a same-cycle bypass of the bank being written. The stimulus reaches the seam with a directed connection map that routes nibble 63 into slot 0 of two outputs, and routes nibble 0 into slot 63. It also broadcasts one nibble to every output. Random nibble data changes every frame, which exposes any one-frame slip in the double buffer. A separate phase uses a random pick table with random values in the ignored stream bit.

// File: rtl/nts_pkg.sv
package nts_pkg;
  localparam int NUM_IN   = 8;
  localparam int NUM_OUT  = 4;
  localparam int NUM_PICK = 4;
  localparam int SLOTS    = 64;
  localparam int NIB_W    = 4;
  localparam int OVS      = 2;

  localparam int IN_W   = $clog2(NUM_IN);
  localparam int OUT_W  = $clog2(NUM_OUT);
  localparam int PICK_W = $clog2(NUM_PICK);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int POS_W  = $clog2(NIB_W);
  localparam int OVS_W  = $clog2(OVS);
  localparam int FRAME_BITS = SLOTS * NIB_W;
  localparam int BIDX_W = $clog2(FRAME_BITS);
  localparam int FRAME_CLKS = FRAME_BITS * OVS;
  localparam int CNT_W  = $clog2(FRAME_CLKS);
  localparam int SRC_W  = IN_W + SLOT_W;
  localparam int CM_W   = 1 + SRC_W;
  localparam int CMA_W  = OUT_W + SLOT_W;

  typedef struct packed {
    logic              sample;
    logic              nibDone;
    logic [SLOT_W-1:0] capSlot;
    logic              wrBank;
    logic              launch;
    logic [SLOT_W-1:0] nextSlot;
    logic [POS_W-1:0]  nextPos;
    logic              rdBank;
  } strobe_t;
endpackage

// File: rtl/nts_ctrl.sv
module nts_ctrl
  import nts_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fpIn,
  output strobe_t strb
);
  logic [CNT_W-1:0]  cnt;
  logic              wrBank;
  logic              wrap;
  logic [OVS_W-1:0]  phase;
  logic [BIDX_W-1:0] bitIdx;
  logic [BIDX_W-1:0] nxtIdx;

  assign phase  = cnt[OVS_W-1:0];
  assign bitIdx = cnt[CNT_W-1:OVS_W];
  assign wrap   = fpIn || (cnt == CNT_W'(FRAME_CLKS - 1));
  assign nxtIdx = fpIn ? '0 : bitIdx + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      wrBank <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) wrBank <= ~wrBank;
    end
  end

  always_comb begin
    strb.sample   = (phase == OVS_W'(OVS - 1));
    strb.nibDone  = strb.sample && (bitIdx[POS_W-1:0] == POS_W'(NIB_W - 1));
    strb.capSlot  = bitIdx[BIDX_W-1:POS_W];
    strb.wrBank   = wrBank;
    strb.launch   = strb.sample || fpIn;
    strb.nextSlot = nxtIdx[BIDX_W-1:POS_W];
    strb.nextPos  = nxtIdx[POS_W-1:0];
    strb.rdBank   = wrap ? wrBank : ~wrBank;
  end
endmodule

// File: rtl/nts_datapath.sv
module nts_datapath
  import nts_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [NUM_IN-1:0]        serIn,
  input  logic                     nbMode,
  input  logic [NUM_PICK*IN_W-1:0] streamPick,
  input  logic                     cmWe,
  input  logic [CMA_W-1:0]         cmAddr,
  input  logic [CM_W-1:0]          cmData,
  output logic [NUM_OUT-1:0]       serOut
);
  logic [NIB_W-2:0] shReg   [NUM_IN];
  logic [NIB_W-1:0] fresh   [NUM_IN];
  logic [NIB_W-1:0] dataMem [2][NUM_IN][SLOTS];
  logic [SRC_W-1:0] cmSrc   [NUM_OUT][SLOTS];
  logic             cmEn    [NUM_OUT][SLOTS];

  logic [OUT_W-1:0]  wrOut;
  logic [SLOT_W-1:0] wrSlot;
  assign wrOut  = cmAddr[CMA_W-1:SLOT_W];
  assign wrSlot = cmAddr[SLOT_W-1:0];

  // Nibble capture: one shift register per input stream
  for (genvar s = 0; s < NUM_IN; s++) begin : g_cap
    assign fresh[s] = {shReg[s], serIn[s]};
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg[s] <= '0;
      else if (strb.sample) shReg[s] <= fresh[s][NIB_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.nibDone)
      for (int s = 0; s < NUM_IN; s++)
        dataMem[strb.wrBank][s][strb.capSlot] <= fresh[s];
  end

  // Connection memory: enables are reset, routes are not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_OUT; o++)
        for (int n = 0; n < SLOTS; n++)
          cmEn[o][n] <= 1'b0;
    end else if (cmWe) begin
      cmEn[wrOut][wrSlot] <= cmData[CM_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (cmWe) cmSrc[wrOut][wrSlot] <= cmData[SRC_W-1:0];
  end

  // Output serialisation, one lane per output stream
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SRC_W-1:0]  ent;
    logic [SLOT_W-1:0] srcNib;
    logic [IN_W-1:0]   srcStr;
    logic [PICK_W-1:0] pickIdx;
    logic [NIB_W-1:0]  nib;
    logic              bypass;
    logic              bitVal;
    logic              outQ;

    assign ent     = cmSrc[o][strb.nextSlot];
    assign srcNib  = ent[SLOT_W-1:0];
    assign pickIdx = ent[SLOT_W +: PICK_W];
    assign srcStr  = nbMode ? streamPick[pickIdx*IN_W +: IN_W] : ent[SLOT_W +: IN_W];
    assign bypass  = strb.nibDone && (strb.rdBank == strb.wrBank) && (srcNib == strb.capSlot);
    assign nib     = bypass ? fresh[srcStr] : dataMem[strb.rdBank][srcStr][srcNib];
    assign bitVal  = cmEn[o][strb.nextSlot] && nib[POS_W'(NIB_W - 1) - strb.nextPos];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outQ <= 1'b0;
      else if (strb.launch) outQ <= bitVal;
    end
    assign serOut[o] = outQ;
  end
endmodule

// File: rtl/nibble_tdm_switch.sv
module nibble_tdm_switch
  import nts_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fpIn,
  input  logic [NUM_IN-1:0]        serIn,
  input  logic                     nbMode,
  input  logic [NUM_PICK*IN_W-1:0] streamPick,
  input  logic                     cmWe,
  input  logic [CMA_W-1:0]         cmAddr,
  input  logic [CM_W-1:0]          cmData,
  output logic [NUM_OUT-1:0]       serOut
);
  strobe_t strb;

  nts_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .fpIn (fpIn),
    .strb (strb)
  );

  nts_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .serIn      (serIn),
    .nbMode     (nbMode),
    .streamPick (streamPick),
    .cmWe       (cmWe),
    .cmAddr     (cmAddr),
    .cmData     (cmData),
    .serOut     (serOut)
  );
endmodule

// File: rtl/nts_chk.sv
module nts_chk
  import nts_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               fpIn,
  input logic [NUM_OUT-1:0] serOut,
  input strobe_t            strb
);
  // R1
  frame_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    fpIn |=> (strb.capSlot == '0 && !strb.sample));

  // R10
  bit_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> $past(strb.launch));

  // R2
  nib_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.nibDone |=> !strb.nibDone);

  // R4
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(strb.wrBank) |-> ($past(fpIn) ||
      $past(strb.nibDone && strb.capSlot == SLOT_W'(SLOTS - 1))));
endmodule

bind nibble_tdm_switch nts_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .fpIn   (fpIn),
  .serOut (serOut),
  .strb   (strb)
);

// File: tb/nibble_tdm_switch_tb_top.sv
module nibble_tdm_switch_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fpIn = 1'b0;
  logic [7:0]  serIn = '0;
  logic        nbMode = 1'b0;
  logic [11:0] streamPick = '0;
  logic        cmWe = 1'b0;
  logic [7:0]  cmAddr = '0;
  logic [9:0]  cmData = '0;
  logic [3:0]  serOut;

  int checks = 0;
  int errors = 0;

  logic [3:0] dat    [2][8][64];
  logic       mEn    [4][64];
  logic [8:0] mSrc   [4][64];
  logic       stEn   [4][64];
  logic [8:0] stSrc  [4][64];
  logic [2:0] mPick  [4];
  logic       mNb = 1'b0;
  bit         allOnes = 1'b0;

  always #10 clk = ~clk;

  nibble_tdm_switch dut_i (
    .clk(clk), .rstN(rstN), .fpIn(fpIn), .serIn(serIn), .nbMode(nbMode),
    .streamPick(streamPick), .cmWe(cmWe), .cmAddr(cmAddr), .cmData(cmData),
    .serOut(serOut)
  );

  function automatic logic expBit(int o, int f, int c);
    int slot = c >> 3;
    int pos  = (c >> 1) & 3;
    int str;
    if (!mEn[o][slot]) return 1'b0;
    str = mNb ? int'(mPick[mSrc[o][slot][7:6]]) : int'(mSrc[o][slot][8:6]);
    return dat[(f + 1) % 2][str][mSrc[o][slot][5:0]][3 - pos];
  endfunction

  function automatic string tagOf(int o, int f, int c);
    int slot = c >> 3;
    string t;
    if (f == 0) t = "R8";
    else if (!mEn[o][slot]) t = "R7";
    else if (slot == 0 && mSrc[o][slot][5:0] == 6'd63) t = "R9";
    else if (mNb) t = "R3/R6/R2";
    else t = "R1/R2/R3/R4/R5";
    if ((c & 1) == 0) t = {t, "/R10"};
    return t;
  endfunction

  task automatic check(string tag, int o, int f, int c, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s out%0d frame %0d clk %0d: actual %0b expected %0b",
               tag, o, f, c, act, exp);
    end
  endtask

  task automatic runFrame(int f, bit chk, bit cfg);
    for (int c = 0; c < 512; c++) begin
      if (c == 0)
        for (int s = 0; s < 8; s++)
          for (int n = 0; n < 64; n++)
            dat[f % 2][s][n] = allOnes ? 4'hF : 4'($urandom_range(0, 15));
      if (chk)
        for (int o = 0; o < 4; o++)
          check(tagOf(o, f, c), o, f, c, serOut[o], expBit(o, f, c));
      for (int s = 0; s < 8; s++)
        serIn[s] = dat[f % 2][s][c >> 3][3 - ((c >> 1) & 3)];
      fpIn = (c == 511);
      if (cfg && c < 256) begin
        cmWe   = 1'b1;
        cmAddr = 8'(c);
        cmData = {stEn[c >> 6][c & 63], stSrc[c >> 6][c & 63]};
      end else begin
        cmWe = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    cmWe = 1'b0;
    if (cfg)
      for (int o = 0; o < 4; o++)
        for (int n = 0; n < 64; n++) begin
          mEn[o][n]  = stEn[o][n];
          mSrc[o][n] = stSrc[o][n];
        end
  endtask

  task automatic stageRandom(int enPct);
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 64; n++) begin
        stEn[o][n]  = ($urandom_range(0, 99) < enPct);
        stSrc[o][n] = 9'($urandom_range(0, 511));
      end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 64; n++) begin
        mEn[o][n] = 1'b0;
        mSrc[o][n] = '0;
      end
    for (int i = 0; i < 4; i++) mPick[i] = '0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet while reset is held
    for (int o = 0; o < 4; o++) check("R8", o, 0, 0, serOut[o], 1'b0);
    rstN = 1'b1;

    runFrame(0, 1'b1, 1'b0);                // R8 reset state, no routes
    stageRandom(75);
    runFrame(1, 1'b0, 1'b1);                // blocking random map
    for (int f = 2; f < 5; f++) runFrame(f, 1'b1, 1'b0);

    stageRandom(70);                        // directed seam and broadcast cases
    stEn[0][0] = 1'b1;  stSrc[0][0]  = {3'd7, 6'd63};   // R9
    stEn[2][0] = 1'b1;  stSrc[2][0]  = {3'd7, 6'd63};   // R9
    stEn[1][63] = 1'b1; stSrc[1][63] = {3'd0, 6'd0};
    for (int o = 0; o < 4; o++) begin                    // R5 broadcast
      stEn[o][5] = 1'b1; stSrc[o][5] = {3'd3, 6'd10};
    end
    stEn[3][7] = 1'b0;
    runFrame(5, 1'b0, 1'b1);
    for (int f = 6; f < 8; f++) runFrame(f, 1'b1, 1'b0);

    stageRandom(80);                        // R6 non-blocking with pick table
    for (int i = 0; i < 4; i++) mPick[i] = 3'($urandom_range(0, 7));
    streamPick = {mPick[3], mPick[2], mPick[1], mPick[0]};
    nbMode = 1'b1;
    mNb = 1'b1;
    runFrame(8, 1'b0, 1'b1);
    for (int f = 9; f < 11; f++) runFrame(f, 1'b1, 1'b0);

    stageRandom(0);                         // R7 disabled with all-ones data
    allOnes = 1'b1;
    runFrame(11, 1'b0, 1'b1);
    runFrame(12, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule